// File: doc/BRIEF.md
# Banked Multi-Port Read Buffer

This block is an on-chip element buffer divided into B banks that accepts up to P read requests in the same clock cycle. Element addresses are interleaved on their low-order bits, so element `e` sits in bank `e mod B` at row `e div B`. A group of ports reading a sliding window of consecutive elements, with port `p` at `base+p`, therefore always lands on distinct banks when P does not exceed B. The whole window is then served in one cycle. This is the access pattern of a direct-form convolution.

A per-bank arbiter detects ports that collide on one bank. It grants the lowest-numbered of them and raises a stall on the others. Stalled ports keep their request unchanged and compete again on the next cycle. A colliding group is therefore serialized over as many cycles as there are requests on the busiest bank.

Each granted read returns its data on a per-port response channel one cycle after the grant. A single write port fills the buffer with one element per cycle. A read granted in the same cycle as a write to the same element returns the value held before that write.

Top module: `bmr_banked_read`

## Requirements
- R1: Element address `e` maps to bank `e mod B`. Two active ports whose addresses are equal modulo B collide. Ports whose addresses differ modulo B never collide.
- R2: When every active request targets a different bank, no port stalls and all requests are granted in that cycle.
- R3: When port `p` requests address `base+p` for every port, with P ≤ B, all P requests are granted in the same cycle.
- R4: Among the active ports that target one bank, the lowest-numbered port is granted. Every other active port on that bank sees `stall_o` high in that cycle.
- R5: A stalled port that holds its request is granted on a later cycle. A set of requests finishes in exactly as many cycles as the largest number of requests on any single bank.
- R6: `rsp_valid_o[p]` is high exactly one cycle after port `p` is granted, and low otherwise. `rsp_data_o` field `p` (bits `p*W` upward) then carries the element at the granted address.
- R7: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` at the clock edge. A read granted in any later cycle returns that value.
- R8: A read granted in the same cycle as a write to the same address returns the value held before the write.
- R9: While `rst_ni` is low, and after reset with no requests, `rsp_valid_o` and `stall_o` are all zero.
- R10: A port with `req_valid_i` low never stalls and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | P | Read request valid, one bit per port |
| req_addr_i | input | P*AW | Read element address, field p at bits p*AW upward |
| stall_o | output | P | Request not granted this cycle; hold and retry |
| rsp_valid_o | output | P | Read data valid, one bit per port |
| rsp_data_o | output | P*W | Read data, field p at bits p*W upward |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | AW | Write element address |
| wr_data_i | input | W | Write data |

## Verification
Stall is a combinational function of the current requests, so the bench samples it in the cycle the requests are driven, 1 ns after the falling edge. A response is due at the first falling edge after the granting rising edge, because the only registers in the path are the bank read register and the response-valid register. The bench checks `rsp_valid_o` and the data there, before it drives the next request set. Expected grants come from a lowest-port-per-bank model. Expected data comes from a shadow array that is updated only after the write edge, which makes the same-cycle write return the old value.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // Width of an index into n items, never below 1.
  function automatic int unsigned log2c(input int unsigned n);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < n) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/bmr_arb.sv
module bmr_arb #(
  parameter int unsigned P  = 4,
  parameter int unsigned B  = 4,
  parameter int unsigned BW = 2,
  parameter int unsigned PW = 2
) (
  input  logic [P-1:0]    req_valid_i,
  input  logic [P*BW-1:0] bank_i,
  output logic [P-1:0]    grant_o,
  output logic [B-1:0]    bank_busy_o,
  output logic [B*PW-1:0] bank_owner_o
);
  always_comb begin
    bank_busy_o  = '0;
    bank_owner_o = '0;
    // descending scan: the last writer, the lowest port, owns the bank
    for (int p = P - 1; p >= 0; p--) begin
      if (req_valid_i[p]) begin
        bank_busy_o[bank_i[p*BW +: BW]] = 1'b1;
        bank_owner_o[int'(bank_i[p*BW +: BW])*PW +: PW] = PW'(p);
      end
    end
    for (int p = 0; p < P; p++) begin
      grant_o[p] = req_valid_i[p] &&
                   (bank_owner_o[int'(bank_i[p*BW +: BW])*PW +: PW] == PW'(p));
    end
  end
endmodule

// File: rtl/bmr_bank.sv
module bmr_bank #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned RW   = 4,
  parameter int unsigned W    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [RW-1:0] rd_row_i,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_row_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [ROWS];

  // read register samples before the write lands: same-cycle read sees old data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_row_i];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_row_i] <= wr_data_i;
  end
endmodule

// File: rtl/bmr_rsp_route.sv
module bmr_rsp_route #(
  parameter int unsigned P  = 4,
  parameter int unsigned B  = 4,
  parameter int unsigned BW = 2,
  parameter int unsigned W  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [P-1:0]    grant_i,
  input  logic [P*BW-1:0] bank_i,
  input  logic [B*W-1:0]  bank_data_i,
  output logic [P-1:0]    rsp_valid_o,
  output logic [P*W-1:0]  rsp_data_o
);
  logic [BW-1:0] sel_q [P];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      for (int p = 0; p < P; p++) sel_q[p] <= '0;
    end else begin
      rsp_valid_o <= grant_i;
      for (int p = 0; p < P; p++) sel_q[p] <= bank_i[p*BW +: BW];
    end
  end

  always_comb begin
    for (int p = 0; p < P; p++)
      rsp_data_o[p*W +: W] = bank_data_i[int'(sel_q[p])*W +: W];
  end
endmodule

// File: rtl/bmr_banked_read.sv
module bmr_banked_read #(
  parameter int unsigned P     = 4,
  parameter int unsigned B     = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = bmr_pkg::log2c(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [P-1:0]    req_valid_i,
  input  logic [P*AW-1:0] req_addr_i,
  output logic [P-1:0]    stall_o,
  output logic [P-1:0]    rsp_valid_o,
  output logic [P*W-1:0]  rsp_data_o,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [W-1:0]    wr_data_i
);
  localparam int unsigned BW   = bmr_pkg::log2c(B);
  localparam int unsigned PW   = bmr_pkg::log2c(P);
  localparam int unsigned ROWS = DEPTH / B;
  localparam int unsigned RW   = bmr_pkg::log2c(ROWS);

  logic [P*BW-1:0] port_bank;
  logic [RW-1:0]   port_row [P];
  logic [P-1:0]    grant;
  logic [B-1:0]    bank_busy;
  logic [B*PW-1:0] bank_owner;
  logic [RW-1:0]   bank_row [B];
  logic [B*W-1:0]  bank_data;

  for (genvar p = 0; p < P; p++) begin : g_port
    assign port_bank[p*BW +: BW] = req_addr_i[p*AW +: BW];
    assign port_row[p]           = req_addr_i[p*AW+BW +: RW];
  end

  bmr_arb #(.P(P), .B(B), .BW(BW), .PW(PW)) u_arb (
    .req_valid_i  (req_valid_i),
    .bank_i       (port_bank),
    .grant_o      (grant),
    .bank_busy_o  (bank_busy),
    .bank_owner_o (bank_owner)
  );

  assign stall_o = req_valid_i & ~grant;

  always_comb begin
    for (int b = 0; b < B; b++)
      bank_row[b] = port_row[bank_owner[b*PW +: PW]];
  end

  for (genvar b = 0; b < B; b++) begin : g_bank
    bmr_bank #(.ROWS(ROWS), .RW(RW), .W(W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (bank_busy[b]),
      .rd_row_i  (bank_row[b]),
      .wr_en_i   (wr_en_i && (wr_addr_i[BW-1:0] == BW'(b))),
      .wr_row_i  (wr_addr_i[BW +: RW]),
      .wr_data_i (wr_data_i),
      .rd_data_o (bank_data[b*W +: W])
    );
  end

  bmr_rsp_route #(.P(P), .B(B), .BW(BW), .W(W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .bank_i      (port_bank),
    .bank_data_i (bank_data),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/bmr_banked_read_chk.sv
module bmr_banked_read_chk #(
  parameter int unsigned P     = 4,
  parameter int unsigned B     = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = bmr_pkg::log2c(DEPTH),
  localparam int unsigned BW   = bmr_pkg::log2c(B)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [P-1:0]    req_valid_i,
  input logic [P*AW-1:0] req_addr_i,
  input logic [P-1:0]    stall_o,
  input logic [P-1:0]    rsp_valid_o
);
  logic [P-1:0] lower_hit;

  always_comb begin
    for (int q = 0; q < P; q++) begin
      lower_hit[q] = 1'b0;
      for (int p = 0; p < q; p++)
        if (req_valid_i[p] && req_valid_i[q] &&
            (req_addr_i[p*AW +: BW] == req_addr_i[q*AW +: BW]))
          lower_hit[q] = 1'b1;
    end
  end

  for (genvar q = 0; q < P; q++) begin : g_chk
    // R4
    a_r4_lower_port_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lower_hit[q] |-> stall_o[q]);
    // R2
    a_r2_free_bank_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[q] && !lower_hit[q]) |-> !stall_o[q]);
    // R10
    a_r10_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i[q] |-> !stall_o[q]);
    // R6
    a_r6_rsp_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[q] && !stall_o[q]) |=> rsp_valid_o[q]);
    // R6
    a_r6_no_rsp_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i[q] && !stall_o[q]) |=> !rsp_valid_o[q]);
    // R5
    a_r5_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[q] |=> (req_valid_i[q] && $stable(req_addr_i[q*AW +: AW])));
  end
endmodule

bind bmr_banked_read bmr_banked_read_chk #(.P(P), .B(B), .DEPTH(DEPTH), .W(W)) i_chk (.*);

// File: tb/test_bmr_banked_read.sv
module test_bmr_banked_read;
  localparam int P = 4, B = 4, DEPTH = 64, W = 16, AW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [P-1:0]    req_valid = '0;
  logic [P*AW-1:0] req_addr = '0;
  logic [P-1:0]    stall, rsp_valid;
  logic [P*W-1:0]  rsp_data;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [W-1:0]    wr_data = '0;

  int total = 0, fails = 0;
  logic [W-1:0]  model [DEPTH];
  logic [AW-1:0] sa [P];

  always #10 clk = ~clk;

  bmr_banked_read #(.P(P), .B(B), .DEPTH(DEPTH), .W(W)) i_bmr_banked_read (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .stall_o(stall), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Runs one request set to completion; starts and ends at a falling edge.
  task automatic run_set(input logic [P-1:0] mask, input bit we,
                         input logic [AW-1:0] wa, input logic [W-1:0] wd, input string ctx);
    logic [P-1:0] pend, eg;
    logic [W-1:0] ed [P];
    int cnt [B];
    int worst, cyc;
    pend = mask; cyc = 0; worst = 0;
    for (int b = 0; b < B; b++) cnt[b] = 0;
    for (int q = 0; q < P; q++) if (mask[q]) cnt[sa[q] % B]++;
    for (int b = 0; b < B; b++) if (cnt[b] > worst) worst = cnt[b];
    while (pend != 0 && cyc < 8) begin
      req_valid = pend;
      for (int q = 0; q < P; q++) req_addr[q*AW +: AW] = sa[q];
      wr_en = we && (cyc == 0); wr_addr = wa; wr_data = wd;
      #1;
      eg = '0;
      for (int q = 0; q < P; q++) begin
        eg[q] = pend[q];
        for (int p = 0; p < q; p++)
          if (pend[p] && (sa[p] % B) == (sa[q] % B)) eg[q] = 1'b0;
        ed[q] = model[sa[q]];
      end
      chk(stall == (pend & ~eg), {"R4 R1 stall ", ctx}, stall, pend & ~eg);
      pend = pend & stall;
      @(posedge clk);
      if (wr_en) model[wa] = wd;
      @(negedge clk);
      chk(rsp_valid == eg, {"R6 R10 rsp_valid ", ctx}, rsp_valid, eg);
      for (int q = 0; q < P; q++)
        if (eg[q]) chk(rsp_data[q*W +: W] == ed[q], {"R6 R8 data ", ctx},
                       rsp_data[q*W +: W], ed[q]);
      cyc++;
    end
    req_valid = '0; wr_en = 1'b0;
    chk(cyc == worst, {"R5 cycles ", ctx}, cyc, worst);
  endtask

  initial begin
    #(20 * 190000);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0, "R9 rsp_valid in reset", rsp_valid, 0);
    chk(stall == '0, "R9 stall in reset", stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0 && stall == '0, "R9 idle after reset", {rsp_valid, stall}, 0);

    // R7 fill, one element per cycle
    for (int e = 0; e < DEPTH; e++) begin
      wr_en = 1'b1; wr_addr = AW'(e); wr_data = W'(e * 401 + 7);
      @(posedge clk); model[e] = W'(e * 401 + 7);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R3 sliding window
    for (int base = 0; base <= DEPTH - P; base++) begin
      for (int p = 0; p < P; p++) sa[p] = AW'(base + p);
      run_set('1, 1'b0, '0, '0, "R3 window");
    end

    // R1 R2 R4 R5 R10: every bank pattern with every request mask
    for (int pat = 0; pat < 256; pat++) begin
      for (int m = 1; m < 16; m++) begin
        for (int q = 0; q < P; q++)
          sa[q] = AW'((((q * 5 + pat + m) % 16) * 4) + ((pat >> (2 * q)) & 3));
        run_set(P'(m), 1'b0, '0, '0, "R2 pattern");
      end
    end

    // R8 same-cycle write returns old data; stalled port then sees new data (R7)
    for (int k = 0; k < 4; k++) begin
      sa[0] = AW'(k * 13 + 3); sa[1] = sa[0]; sa[2] = AW'(sa[0] + 1); sa[3] = AW'(sa[0] + 2);
      run_set(4'b0111, 1'b1, sa[0], W'(16'hA500 + k), "R8 write-read");
    end

    @(negedge clk);
    chk(rsp_valid == '0 && stall == '0, "R10 idle end", {rsp_valid, stall}, 0);
    summary();
  end
endmodule